// File: doc/BRIEF.md
# Head-per-track disk controller command and status register

This block is the host-facing register slice of a fixed-head disk controller. It holds an 18-bit function and status word, a disk address, a memory address and a word count. Commands arrive as one strobed I/O instruction: a six-bit pulse code and an 18-bit accumulator value. The block answers in the same cycle with an accumulator value, into which any read result is ORed, and with a skip flag.

A separate transfer engine reports completion and faults on event inputs. It is told to begin or abandon a transfer through two single-cycle strobes. The status word is kept consistent at all times. The error summary bit follows the four individual fault flags, done forces busy low, and an interrupt request is raised while an enabled done or error condition stands.

Three pulse bits pick the command groups and two subfunction bits pick the command within each group. When several pulse bits are set in one instruction, the groups act in a fixed order within the cycle: the flag group first, then the read group, then the load group.

Top module: `dkc_ctrl`

## Requirements
- R1: A synchronous active-high reset clears status, disk address, memory address and word count, and drops the interrupt request.
- R2: Pulse bit 0 with subfunction (pulse bits 5:4) 00 clears status bits 17 to 12 (error summary, parity 16, illegal address 15, timing 14, not-ready 13, done 12). Interrupt enable (bit 11), busy (bit 10) and write direction (bit 9) are kept.
- R3: Pulse bit 0 with subfunction 01 raises `io_skip` in the command cycle exactly when status bit 17 or bit 12 is set.
- R4: Pulse bit 0 with subfunction 10 clears the whole status word.
- R5: Pulse bit 1 with subfunction 00 returns `acc_in` ORed with the disk address, where the BCD track sits in bits 16:8 and the BCD sector in bits 7:0. Subfunction 01 returns `acc_in` ORed with the status word. With no read, `acc_out` equals `acc_in`.
- R6: Pulse bit 1 with subfunction 10 loads the memory address from the low `MA_W` accumulator bits. Pulse bit 2 with subfunction 01 loads the word count from the low 16 bits. Neither register changes on any other command.
- R7: Pulse bit 2 with subfunction 00 loads the disk address when every BCD digit is below ten, the track is below `TRACKS` and the sector is below `SECTORS`. Otherwise the old address is kept and the illegal-address flag (bit 15) is set.
- R8: Pulse bit 2 with subfunction 10 sets status to (old status AND octal 007000) XOR (accumulator AND NOT octal 000777). Status bits 8:0 always read zero.
- R9: A status load whose result has busy set pulses `xfer_start` in that cycle. A status load whose result has busy clear pulses `xfer_cancel`. The two never pulse together.
- R10: Bit 17 always equals the OR of bits 16 to 13, and done set forces busy clear.
- R11: `irq` is high exactly while (bit 17 or bit 12) and bit 11 are set.
- R12: Within one instruction, the flag group acts before the read group, and the read group acts before the load group.
- R13: The engine event inputs set done, parity, illegal address, timing and not-ready in the status word. They take effect whether or not a command is present, and a same-cycle flag clear still wins.
- R14: Nothing changes when `iot_valid` is low, and subfunction 11 is a no-op in every group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iot_valid | input | 1 | Instruction strobe, one cycle per command |
| iot_pulse | input | 6 | Bits 2:0 group select, bits 5:4 subfunction |
| acc_in | input | 18 | Host accumulator value |
| acc_out | output | 18 | Accumulator returned to the host |
| io_skip | output | 1 | Skip condition for the current instruction |
| eng_done | input | 1 | Transfer engine finished |
| eng_parity | input | 1 | Engine parity fault |
| eng_bad_addr | input | 1 | Engine address or write-lock fault |
| eng_timing | input | 1 | Engine timing fault |
| eng_not_ready | input | 1 | Engine medium not ready |
| status | output | 18 | Function and status word |
| irq | output | 1 | Interrupt request |
| xfer_start | output | 1 | Start strobe to the engine |
| xfer_cancel | output | 1 | Cancel strobe to the engine |
| disk_addr | output | 17 | Current BCD disk address |
| mem_addr | output | MA_W | Current memory address |
| word_cnt | output | WC_W | Current word count |

## Verification
The hardest states to reach are those where two command groups act in a single instruction, so that the order between them decides the result. A flag clear followed by an invalid address load in the same cycle must leave the illegal-address flag set. A full clear followed by a status load must XOR against zero rather than the old word. A disk-address read combined with a load must return the address from before the load. The vector table reaches each of these by first steering status and the address into a known non-zero state, then issuing the multi-bit pulse codes 05, 06 and 25 (hex). Engine events are driven in cycles with no command, so the bench can observe normalization and the interrupt on their own.

// File: rtl/dkc_pkg.sv
package dkc_pkg;

    localparam int ST_W  = 18;
    localparam int DA_W  = 17;

    localparam int B_ERR  = 17;
    localparam int B_PAR  = 16;
    localparam int B_ILA  = 15;
    localparam int B_TIM  = 14;
    localparam int B_NRDY = 13;
    localparam int B_DONE = 12;
    localparam int B_IE   = 11;
    localparam int B_BUSY = 10;
    localparam int B_WR   = 9;

    localparam logic [ST_W-1:0] M_LOW   = 18'o000777;
    localparam logic [ST_W-1:0] M_KEEP  = 18'o007000;
    localparam logic [ST_W-1:0] M_FAULT = 18'o360000;
    localparam logic [ST_W-1:0] M_FLAGS = 18'o770000;

    localparam logic [1:0] SUB_A = 2'b00;
    localparam logic [1:0] SUB_B = 2'b01;
    localparam logic [1:0] SUB_C = 2'b10;

    typedef struct packed {
        logic clr_flags;
        logic skip_test;
        logic clr_all;
        logic rd_addr;
        logic rd_stat;
        logic ld_ma;
        logic ld_addr;
        logic ld_wc;
        logic ld_stat;
    } cmd_t;

    typedef struct packed {
        logic done;
        logic parity;
        logic bad_addr;
        logic timing;
        logic not_ready;
    } evt_t;

    function automatic logic [ST_W-1:0] st_normalize(input logic [ST_W-1:0] s);
        logic [ST_W-1:0] r;
        r = s & ~M_LOW;
        r[B_ERR] = |(r & M_FAULT);
        if (r[B_DONE]) r[B_BUSY] = 1'b0;
        return r;
    endfunction

    function automatic logic bcd_digits_ok(input logic [11:0] v);
        logic ok;
        ok = 1'b1;
        for (int d = 0; d < 3; d++) begin
            if (v[d*4 +: 4] > 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic int bcd_value(input logic [11:0] v);
        int r;
        int w;
        r = 0;
        w = 1;
        for (int d = 0; d < 3; d++) begin
            r = r + int'(v[d*4 +: 4]) * w;
            w = w * 10;
        end
        return r;
    endfunction

endpackage

// File: rtl/dkc_cmd_decode.sv
module dkc_cmd_decode
    import dkc_pkg::*;
(
    input  logic       valid_i,
    input  logic [5:0] pulse_i,
    output cmd_t       cmd_o
);
    logic [1:0] sub;
    logic       g_flag, g_read, g_load;

    assign sub    = pulse_i[5:4];
    assign g_flag = valid_i & pulse_i[0];
    assign g_read = valid_i & pulse_i[1];
    assign g_load = valid_i & pulse_i[2];

    always_comb begin
        cmd_o.clr_flags = g_flag & (sub == SUB_A);
        cmd_o.skip_test = g_flag & (sub == SUB_B);
        cmd_o.clr_all   = g_flag & (sub == SUB_C);
        cmd_o.rd_addr   = g_read & (sub == SUB_A);
        cmd_o.rd_stat   = g_read & (sub == SUB_B);
        cmd_o.ld_ma     = g_read & (sub == SUB_C);
        cmd_o.ld_addr   = g_load & (sub == SUB_A);
        cmd_o.ld_wc     = g_load & (sub == SUB_B);
        cmd_o.ld_stat   = g_load & (sub == SUB_C);
    end
endmodule

// File: rtl/dkc_addr_regs.sv
module dkc_addr_regs
    import dkc_pkg::*;
#(
    parameter int MA_W    = 15,
    parameter int WC_W    = 16,
    parameter int TRACKS  = 200,
    parameter int SECTORS = 80
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_addr_i,
    input  logic            ld_ma_i,
    input  logic            ld_wc_i,
    input  logic [DA_W-1:0] acc_i,
    output logic [DA_W-1:0] da_o,
    output logic [MA_W-1:0] ma_o,
    output logic [WC_W-1:0] wc_o,
    output logic            addr_bad_o
);
    localparam int TRK_W = 9;
    localparam int SEC_W = DA_W - TRK_W;

    logic [11:0] trk_bcd, sec_bcd;
    logic        addr_ok;

    assign trk_bcd = {{(12-TRK_W){1'b0}}, acc_i[DA_W-1:SEC_W]};
    assign sec_bcd = {{(12-SEC_W){1'b0}}, acc_i[SEC_W-1:0]};

    always_comb begin
        addr_ok = bcd_digits_ok(trk_bcd) && bcd_digits_ok(sec_bcd) &&
                  (bcd_value(trk_bcd) < TRACKS) && (bcd_value(sec_bcd) < SECTORS);
    end

    assign addr_bad_o = ld_addr_i & ~addr_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            da_o <= '0;
            ma_o <= '0;
            wc_o <= '0;
        end else begin
            if (ld_addr_i && addr_ok) da_o <= acc_i;
            if (ld_ma_i) ma_o <= acc_i[MA_W-1:0];
            if (ld_wc_i) wc_o <= acc_i[WC_W-1:0];
        end
    end
endmodule

// File: rtl/dkc_status_reg.sv
module dkc_status_reg
    import dkc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            clr_flags_i,
    input  logic            skip_test_i,
    input  logic            clr_all_i,
    input  logic            ld_stat_i,
    input  logic            addr_bad_i,
    input  evt_t            evt_i,
    input  logic [ST_W-1:0] acc_i,
    output logic [ST_W-1:0] stat_o,
    output logic [ST_W-1:0] stat_mid_o,
    output logic            skip_o,
    output logic            start_o,
    output logic            cancel_o
);
    logic [ST_W-1:0] stat_q, stage, nxt;

    always_comb begin
        stage = stat_q;
        stage[B_DONE] = stage[B_DONE] | evt_i.done;
        stage[B_PAR]  = stage[B_PAR]  | evt_i.parity;
        stage[B_ILA]  = stage[B_ILA]  | evt_i.bad_addr;
        stage[B_TIM]  = stage[B_TIM]  | evt_i.timing;
        stage[B_NRDY] = stage[B_NRDY] | evt_i.not_ready;
        stage = st_normalize(stage);
        if (clr_flags_i) stage = stage & ~M_FLAGS;
        if (clr_all_i)   stage = '0;
        nxt = stage;
        if (addr_bad_i) nxt[B_ILA] = 1'b1;
        if (ld_stat_i)  nxt = (nxt & M_KEEP) ^ (acc_i & ~M_LOW);
        nxt = st_normalize(nxt);
    end

    assign stat_mid_o = stage;
    assign skip_o     = skip_test_i & (stage[B_ERR] | stage[B_DONE]);
    assign start_o    = ld_stat_i & nxt[B_BUSY];
    assign cancel_o   = ld_stat_i & ~nxt[B_BUSY];
    assign stat_o     = stat_q;

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= nxt;
    end
endmodule

// File: rtl/dkc_ctrl.sv
module dkc_ctrl
    import dkc_pkg::*;
#(
    parameter int MA_W    = 15,
    parameter int WC_W    = 16,
    parameter int TRACKS  = 200,
    parameter int SECTORS = 80
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             iot_valid,
    input  logic [5:0]       iot_pulse,
    input  logic [17:0]      acc_in,
    output logic [17:0]      acc_out,
    output logic             io_skip,
    input  logic             eng_done,
    input  logic             eng_parity,
    input  logic             eng_bad_addr,
    input  logic             eng_timing,
    input  logic             eng_not_ready,
    output logic [17:0]      status,
    output logic             irq,
    output logic             xfer_start,
    output logic             xfer_cancel,
    output logic [16:0]      disk_addr,
    output logic [MA_W-1:0]  mem_addr,
    output logic [WC_W-1:0]  word_cnt
);
    cmd_t            cmd;
    evt_t            evt;
    logic            addr_bad;
    logic [ST_W-1:0] stat_mid;
    logic [ST_W-1:0] rd_bus;

    assign evt = '{done: eng_done, parity: eng_parity, bad_addr: eng_bad_addr,
                   timing: eng_timing, not_ready: eng_not_ready};

    dkc_cmd_decode u_dec (
        .valid_i (iot_valid),
        .pulse_i (iot_pulse),
        .cmd_o   (cmd)
    );

    dkc_addr_regs #(
        .MA_W(MA_W), .WC_W(WC_W), .TRACKS(TRACKS), .SECTORS(SECTORS)
    ) u_addr (
        .clk        (clk),
        .rst        (rst),
        .ld_addr_i  (cmd.ld_addr),
        .ld_ma_i    (cmd.ld_ma),
        .ld_wc_i    (cmd.ld_wc),
        .acc_i      (acc_in[DA_W-1:0]),
        .da_o       (disk_addr),
        .ma_o       (mem_addr),
        .wc_o       (word_cnt),
        .addr_bad_o (addr_bad)
    );

    dkc_status_reg u_stat (
        .clk         (clk),
        .rst         (rst),
        .clr_flags_i (cmd.clr_flags),
        .skip_test_i (cmd.skip_test),
        .clr_all_i   (cmd.clr_all),
        .ld_stat_i   (cmd.ld_stat),
        .addr_bad_i  (addr_bad),
        .evt_i       (evt),
        .acc_i       (acc_in),
        .stat_o      (status),
        .stat_mid_o  (stat_mid),
        .skip_o      (io_skip),
        .start_o     (xfer_start),
        .cancel_o    (xfer_cancel)
    );

    always_comb begin
        rd_bus = '0;
        if (cmd.rd_addr) rd_bus = rd_bus | {1'b0, disk_addr};
        if (cmd.rd_stat) rd_bus = rd_bus | stat_mid;
    end

    assign acc_out = acc_in | rd_bus;
    assign irq     = (status[B_ERR] | status[B_DONE]) & status[B_IE];
endmodule

// File: rtl/dkc_ctrl_chk.sv
module dkc_ctrl_chk #(
    parameter int MA_W = 15,
    parameter int WC_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            iot_valid,
    input logic [5:0]      iot_pulse,
    input logic            eng_done,
    input logic            eng_parity,
    input logic            eng_bad_addr,
    input logic            eng_timing,
    input logic            eng_not_ready,
    input logic [17:0]     status,
    input logic            irq,
    input logic            xfer_start,
    input logic            xfer_cancel,
    input logic [MA_W-1:0] mem_addr,
    input logic [WC_W-1:0] word_cnt
);
    logic any_evt;
    logic wc_cmd, ma_cmd, wipe_cmd;

    assign any_evt  = eng_done | eng_parity | eng_bad_addr | eng_timing | eng_not_ready;
    assign wc_cmd   = iot_valid & iot_pulse[2] & (iot_pulse[5:4] == 2'b01);
    assign ma_cmd   = iot_valid & iot_pulse[1] & (iot_pulse[5:4] == 2'b10);
    assign wipe_cmd = iot_valid & iot_pulse[0] & ~iot_pulse[2] & (iot_pulse[5:4] == 2'b10) & ~any_evt;

    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (rst) status[8:0] == 9'd0); // R8
    AST_SUMMARY_FOLLOWS_FLAGS: assert property (@(posedge clk) disable iff (rst) status[17] == |status[16:13]); // R10
    AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (rst) status[12] |-> !status[10]); // R10
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst) irq |-> status[11]); // R11
    AST_IRQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (rst) irq |-> (status[17] || status[12])); // R11
    AST_FULL_CLEAR: assert property (@(posedge clk) disable iff (rst) wipe_cmd |=> status == 18'd0); // R4
    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst) xfer_start |=> status[10]); // R9
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(xfer_start && xfer_cancel)); // R9
    AST_WC_HOLDS: assert property (@(posedge clk) disable iff (rst) !wc_cmd |=> $stable(word_cnt)); // R6
    AST_MA_HOLDS: assert property (@(posedge clk) disable iff (rst) !ma_cmd |=> $stable(mem_addr)); // R6
endmodule

bind dkc_ctrl dkc_ctrl_chk #(.MA_W(MA_W), .WC_W(WC_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .iot_valid     (iot_valid),
    .iot_pulse     (iot_pulse),
    .eng_done      (eng_done),
    .eng_parity    (eng_parity),
    .eng_bad_addr  (eng_bad_addr),
    .eng_timing    (eng_timing),
    .eng_not_ready (eng_not_ready),
    .status        (status),
    .irq           (irq),
    .xfer_start    (xfer_start),
    .xfer_cancel   (xfer_cancel),
    .mem_addr      (mem_addr),
    .word_cnt      (word_cnt)
);

// File: tb/dkc_ctrl_test.sv
module dkc_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int MA_W = 15;
    localparam int WC_W = 16;

    typedef struct packed {
        logic [5:0]  pulse;
        logic [17:0] acc;
        logic [17:0] exp_acc;
        logic        exp_skip;
        logic [17:0] exp_st;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{6'h12, 18'o000000, 18'o000000, 1'b0, 18'o000000}, // R5 read status after reset
        '{6'h24, 18'o004000, 18'o004000, 1'b0, 18'o004000}, // R8 set enable
        '{6'h24, 18'o001777, 18'o001777, 1'b0, 18'o005000}, // R8 low bits masked
        '{6'h24, 18'o004000, 18'o004000, 1'b0, 18'o001000}, // R8 xor toggles enable off
        '{6'h24, 18'o012000, 18'o012000, 1'b0, 18'o011000}, // R10 done drops busy
        '{6'h11, 18'o000000, 18'o000000, 1'b1, 18'o011000}, // R3 skip on done
        '{6'h24, 18'o214000, 18'o214000, 1'b0, 18'o615000}, // R8 R10 done not kept, parity sums
        '{6'h12, 18'o000005, 18'o615005, 1'b0, 18'o615000}, // R5 status ORed in
        '{6'h01, 18'o000000, 18'o000000, 1'b0, 18'o005000}, // R2 flag clear
        '{6'h11, 18'o000000, 18'o000000, 1'b0, 18'o005000}, // R3 no skip
        '{6'h04, 18'h19979,  18'h19979,  1'b0, 18'o005000}, // R7 track 199 sector 79
        '{6'h02, 18'h20000,  18'h39979,  1'b0, 18'o005000}, // R5 address ORed in
        '{6'h04, 18'h1A000,  18'h1A000,  1'b0, 18'o505000}, // R7 bad digit
        '{6'h02, 18'h00000,  18'h19979,  1'b0, 18'o505000}, // R7 address kept
        '{6'h01, 18'o000000, 18'o000000, 1'b0, 18'o005000}, // R2
        '{6'h04, 18'h00080,  18'h00080,  1'b0, 18'o505000}, // R7 sector 80 rejected
        '{6'h02, 18'h00000,  18'h19979,  1'b0, 18'o505000}, // R7
        '{6'h21, 18'o000000, 18'o000000, 1'b0, 18'o000000}, // R4 full clear
        '{6'h24, 18'o004000, 18'o004000, 1'b0, 18'o004000}, // R8
        '{6'h25, 18'o001000, 18'o001000, 1'b0, 18'o001000}, // R12 clear before status load
        '{6'h04, 18'h0000A,  18'h0000A,  1'b0, 18'o501000}, // R7
        '{6'h05, 18'h00012,  18'h00012,  1'b0, 18'o001000}, // R12 clear then valid load
        '{6'h05, 18'h0000A,  18'h0000A,  1'b0, 18'o501000}, // R12 clear then bad load keeps flag
        '{6'h06, 18'h00034,  18'h00036,  1'b0, 18'o501000}, // R12 read before load
        '{6'h02, 18'h00000,  18'h00034,  1'b0, 18'o501000}, // R7 new address
        '{6'h37, 18'h0F0F0,  18'h0F0F0,  1'b0, 18'o501000}  // R14 subfunction 11 no-op
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic iot_valid = 1'b0;
    logic [5:0] iot_pulse = '0;
    logic [17:0] acc_in = '0;
    logic eng_done = 1'b0, eng_parity = 1'b0, eng_bad_addr = 1'b0;
    logic eng_timing = 1'b0, eng_not_ready = 1'b0;
    logic [17:0] acc_out, status;
    logic io_skip, irq, xfer_start, xfer_cancel;
    logic [16:0] disk_addr;
    logic [MA_W-1:0] mem_addr;
    logic [WC_W-1:0] word_cnt;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dkc_ctrl #(.MA_W(MA_W), .WC_W(WC_W)) uut (
        .clk(clk), .rst(rst), .iot_valid(iot_valid), .iot_pulse(iot_pulse),
        .acc_in(acc_in), .acc_out(acc_out), .io_skip(io_skip),
        .eng_done(eng_done), .eng_parity(eng_parity), .eng_bad_addr(eng_bad_addr),
        .eng_timing(eng_timing), .eng_not_ready(eng_not_ready),
        .status(status), .irq(irq), .xfer_start(xfer_start), .xfer_cancel(xfer_cancel),
        .disk_addr(disk_addr), .mem_addr(mem_addr), .word_cnt(word_cnt)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %o expected %o", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [5:0] p, input logic [17:0] a);
        @(negedge clk);
        iot_valid = v;
        iot_pulse = p;
        acc_in    = a;
        #(CLK_PERIOD/4);
    endtask

    task automatic after_edge;
        @(posedge clk);
        #1;
        iot_valid = 1'b0;
        eng_done = 1'b0; eng_parity = 1'b0; eng_bad_addr = 1'b0;
        eng_timing = 1'b0; eng_not_ready = 1'b0;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 status", 32'(status), 32'd0);
        check("R1 irq", 32'(irq), 32'd0);
        check("R1 mem_addr", 32'(mem_addr), 32'd0);
        check("R1 word_cnt", 32'(word_cnt), 32'd0);
        check("R1 disk_addr", 32'(disk_addr), 32'd0);

        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VECS[i].pulse, VECS[i].acc);
            check($sformatf("table %0d acc_out", i), 32'(acc_out), 32'(VECS[i].exp_acc));
            check($sformatf("table %0d io_skip", i), 32'(io_skip), 32'(VECS[i].exp_skip));
            after_edge();
            check($sformatf("table %0d status", i), 32'(status), 32'(VECS[i].exp_st));
        end

        do_reset();
        drive(1'b1, 6'h02, 18'd0);
        check("R1 address read after reset", 32'(acc_out), 32'd0);
        after_edge();

        // R6 memory address and word count loads
        drive(1'b1, 6'h22, 18'o777777);
        after_edge();
        check("R6 mem_addr", 32'(mem_addr), 32'h7FFF);
        drive(1'b1, 6'h14, 18'h3FFFF);
        after_edge();
        check("R6 word_cnt", 32'(word_cnt), 32'hFFFF);
        check("R6 mem_addr held", 32'(mem_addr), 32'h7FFF);

        // R9 start strobe
        drive(1'b1, 6'h24, 18'o006000);
        check("R9 start", 32'(xfer_start), 32'd1);
        check("R9 no cancel", 32'(xfer_cancel), 32'd0);
        after_edge();
        check("R9 busy status", 32'(status), 32'o006000);
        check("R11 irq idle", 32'(irq), 32'd0);

        // R13 engine done without a command
        @(negedge clk);
        eng_done = 1'b1;
        after_edge();
        check("R13 done event", 32'(status), 32'o014000);
        check("R11 irq on done", 32'(irq), 32'd1);

        @(negedge clk);
        eng_parity = 1'b1;
        after_edge();
        check("R13 parity event", 32'(status), 32'o614000);

        // R14 strobe low ignored
        drive(1'b0, 6'h21, 18'o777777);
        after_edge();
        check("R14 valid low", 32'(status), 32'o614000);

        drive(1'b1, 6'h01, 18'd0);
        after_edge();
        check("R2 flags cleared", 32'(status), 32'o004000);
        check("R11 irq dropped", 32'(irq), 32'd0);

        drive(1'b1, 6'h24, 18'o004000);
        check("R9 cancel", 32'(xfer_cancel), 32'd1);
        check("R9 no start", 32'(xfer_start), 32'd0);
        after_edge();
        check("R8 cleared by xor", 32'(status), 32'd0);

        drive(1'b1, 6'h24, 18'o004000);
        after_edge();
        @(negedge clk);
        eng_timing = 1'b1;
        after_edge();
        check("R13 timing event", 32'(status), 32'o444000);
        check("R11 irq on error", 32'(irq), 32'd1);

        @(negedge clk);
        eng_not_ready = 1'b1;
        iot_valid = 1'b1;
        iot_pulse = 6'h01;
        after_edge();
        check("R13 clear wins over event", 32'(status), 32'o004000);

        do_reset();
        check("R1 status after mid reset", 32'(status), 32'd0);
        check("R1 irq after mid reset", 32'(irq), 32'd0);
        check("R1 mem_addr after mid reset", 32'(mem_addr), 32'd0);
        check("R1 word_cnt after mid reset", 32'(word_cnt), 32'd0);

        finish_run();
    end
endmodule